// File: doc/BRIEF.md
# Keyed Watchdog and Interval Timer

This block watches over system software. A 16-bit counter advances on one of two clock-enable inputs and restarts from zero when it reaches a selectable terminal count. In watchdog mode, reaching that count raises a one-cycle system reset request. Software must therefore clear the counter in time or freeze it. In interval mode the same terminal count raises a one-cycle interrupt pulse instead, which gives a periodic tick.

The control word is written through a single 16-bit port. The write takes effect only when the upper byte carries the key 0x5A. Any other upper byte is treated as a fault: it leaves the configuration and the count untouched and raises the reset request. Reads return a fixed tag of 0x69 in the upper byte, so a read-back can never be replayed as a valid write.

Top module: `wdog_guard`

## Requirements
- R1: After reset the control read-back is 0x6900: watchdog mode, tick source A, longest interval, counter not held, counter at zero.
- R2: A write whose upper byte is not 0x5A changes no control field. The cycle after the write edge, `rst_req` is high for one cycle.
- R3: A write keyed with 0x5A loads these low-byte fields: bit 7 hold, bit 4 interval mode (1 = interval, 0 = watchdog), bit 3 counter clear, bit 2 tick source (0 = `tick_a`, 1 = `tick_b`), bits 1:0 interval select.
- R4: `rd_data` carries 0x69 in bits 15:8 and the stored fields in the R3 positions, with bits 6, 5 and 3 reading 0. The clear bit therefore always reads back as 0.
- R5: Interval select values 0, 1, 2 and 3 expire after 32768, 8192, 512 and 64 counted ticks respectively, counting from a cleared counter.
- R6: In watchdog mode, the tick that completes the interval sets `rst_req` for exactly the next cycle and restarts the counter from zero.
- R7: In interval mode, every completed interval gives a one-cycle `ivl_irq` pulse, and an expiry never raises `rst_req`.
- R8: Only the tick input chosen by the source bit advances the counter. The other one has no effect.
- R9: While the hold bit is set, the counter does not change. Clearing hold resumes counting from the frozen value.
- R10: A keyed write with the clear bit zeroes the counter. When it falls in the same cycle as the terminal tick, the clear wins and no expiry is signalled.
- R11: An unkeyed write in the same cycle as a terminal tick in watchdog mode gives a single one-cycle `rst_req`, and the counter still restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_a | input | 1 | Count enable, source A |
| tick_b | input | 1 | Count enable, source B |
| wr_en | input | 1 | Control write strobe |
| wr_data | input | 16 | Control write word: key in the upper byte, fields in the lower byte |
| rd_data | output | 16 | Control read-back |
| rst_req | output | 1 | One-cycle system reset request |
| ivl_irq | output | 1 | One-cycle interval interrupt pulse |

## Verification
Two pairs of events can land on the same clock edge: a software clear and the terminal tick, and a key fault and the terminal tick. The bench steps the counter to one tick short of the 64-count interval. It then issues the write in the very cycle that carries the final tick. For the clear case, `rst_req` must stay low and the next expiry must come a full 64 ticks later. For the key-fault case, exactly one reset pulse must appear, and the next expiry must again come 64 ticks later, which shows the counter wrapped.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    // stored control fields
    typedef struct packed {
        logic       hold;
        logic       ivl_mode;
        logic       src_b;
        logic [1:0] tap_sel;
    } wdog_cfg_t;

    // registered outputs of the top
    typedef struct packed {
        logic rst_req;
        logic ivl_irq;
    } wdog_out_t;

endpackage

// File: rtl/wdog_ctrl_reg.sv
module wdog_ctrl_reg
    import wdog_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter logic [7:0]  KEY    = 8'h5A,
    parameter logic [7:0]  RD_TAG = 8'h69
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output wdog_cfg_t         cfg,
    output logic              clr_pulse,
    output logic              key_bad,
    output logic [DATA_W-1:0] rd_data
);
    localparam int unsigned KEY_LSB = DATA_W - 8;

    wdog_cfg_t cfg_d, cfg_q;
    logic      key_ok;

    assign key_ok = (wr_data[DATA_W-1:KEY_LSB] == KEY);

    always_comb begin
        cfg_d     = cfg_q;
        clr_pulse = 1'b0;
        key_bad   = 1'b0;
        if (wr_en) begin
            if (key_ok) begin
                cfg_d.hold     = wr_data[7];
                cfg_d.ivl_mode = wr_data[4];
                cfg_d.src_b    = wr_data[2];
                cfg_d.tap_sel  = wr_data[1:0];
                clr_pulse      = wr_data[3];
            end else begin
                key_bad = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg     = cfg_q;
    assign rd_data = {RD_TAG, {(KEY_LSB-8){1'b0}}, cfg_q.hold, 2'b00,
                      cfg_q.ivl_mode, 1'b0, cfg_q.src_b, cfg_q.tap_sel};

    // R2
    bad_key_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[DATA_W-1:KEY_LSB] != KEY) |=> $stable(cfg_q));

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick_a,
    input  logic      tick_b,
    input  wdog_cfg_t cfg,
    input  logic      clr,
    output logic      expire
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic [CNT_W-1:0] last;
    logic             step;

    // terminal count per interval select
    always_comb begin
        case (cfg.tap_sel)
            2'd0:    last = (ONE << (CNT_W-1))  - ONE;
            2'd1:    last = (ONE << (CNT_W-3))  - ONE;
            2'd2:    last = (ONE << (CNT_W-7))  - ONE;
            default: last = (ONE << (CNT_W-10)) - ONE;
        endcase
    end

    assign step = (cfg.src_b ? tick_b : tick_a) & ~cfg.hold;

    always_comb begin
        cnt_d  = cnt_q;
        expire = 1'b0;
        if (clr) begin
            cnt_d = '0;
        end else if (step) begin
            if (cnt_q >= last) begin
                cnt_d  = '0;
                expire = 1'b1;
            end else begin
                cnt_d = cnt_q + ONE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // R9
    hold_freezes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.hold && !clr) |=> $stable(cnt_q));

    // R10
    clear_zeroes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt_q == '0));

    // R6
    wrap_after_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (cnt_q == '0));

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int unsigned CNT_W  = 16,
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_a,
    input  logic              tick_b,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              rst_req,
    output logic              ivl_irq
);
    wdog_cfg_t cfg;
    logic      clr_pulse, key_bad, expire;
    wdog_out_t out_d, out_q;

    wdog_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .cfg(cfg), .clr_pulse(clr_pulse), .key_bad(key_bad), .rd_data(rd_data)
    );

    wdog_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .cfg(cfg), .clr(clr_pulse), .expire(expire)
    );

    always_comb begin
        out_d         = '0;
        out_d.rst_req = key_bad | (expire & ~cfg.ivl_mode);
        out_d.ivl_irq = expire & cfg.ivl_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign rst_req = out_q.rst_req;
    assign ivl_irq = out_q.ivl_irq;

    // R7
    irq_only_interval_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ivl_irq |-> $past(cfg.ivl_mode));

    // R7
    no_expiry_reset_in_ivl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_req && !$past(wr_en)) |-> !$past(cfg.ivl_mode));

endmodule

// File: tb/wdog_guard_tb.sv
module wdog_guard_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick_a = 1'b0, tick_b = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        rst_req, ivl_irq;
    int          total = 0, bad = 0, cyc = 0;
    int          f_rst, n_rst, f_irq, n_irq;

    always #5 clk = ~clk;

    wdog_guard u_dut (
        .clk(clk), .rst_n(rst_n), .tick_a(tick_a), .tick_b(tick_b),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .rst_req(rst_req), .ivl_irq(ivl_irq)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d cycles expected<=150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d, input bit ta);
        wr_en = 1'b1; wr_data = d; tick_a = ta;
        @(posedge clk); #1;
        wr_en = 1'b0; tick_a = 1'b0;
    endtask

    // n cycles, tick on chosen source each cycle; records first/number of pulses
    task automatic run(input int n, input bit use_b);
        f_rst = 0; n_rst = 0; f_irq = 0; n_irq = 0;
        for (int i = 1; i <= n; i++) begin
            tick_a = !use_b; tick_b = use_b;
            @(posedge clk); #1;
            if (rst_req) begin n_rst++; if (f_rst == 0) f_rst = i; end
            if (ivl_irq) begin n_irq++; if (f_irq == 0) f_irq = i; end
        end
        tick_a = 1'b0; tick_b = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(posedge clk); #1;
        // R1
        chk(rd_data == 16'h6900, "R1 reset readback", rd_data, 16'h6900);
        chk(!rst_req && !ivl_irq, "R1 outputs idle", {rst_req, ivl_irq}, 0);
        // R1 R5 R6 default: longest interval on source A
        run(32770, 1'b0);
        chk(f_rst == 32768, "R5 R6 default expiry tick", f_rst, 32768);
        chk(n_rst == 1, "R6 single pulse", n_rst, 1);

        // R5 sweep of shorter taps on both sources
        for (int s = 1; s < 4; s++) begin
            for (int b = 0; b < 2; b++) begin
                int exp_t;
                exp_t = (s == 1) ? 8192 : (s == 2) ? 512 : 64;
                wr(16'h5A08 | 16'(b << 2) | 16'(s), 1'b0);
                // R3 R4
                chk(rd_data == (16'h6900 | 16'(b << 2) | 16'(s)), "R3 R4 readback",
                    rd_data, 16'h6900 | 16'(b << 2) | 16'(s));
                run(exp_t + 2, b[0]);
                chk(f_rst == exp_t, "R5 tap expiry", f_rst, exp_t);
                chk(n_irq == 0, "R6 no irq in watchdog mode", n_irq, 0);
            end
        end

        // R7 interval mode
        wr(16'h5A1B, 1'b0);
        chk(rd_data == 16'h6913, "R4 clear reads 0", rd_data, 16'h6913);
        run(130, 1'b0);
        chk(f_irq == 64 && n_irq == 2, "R7 periodic irq", n_irq, 2);
        chk(n_rst == 0, "R7 no reset in interval mode", n_rst, 0);

        // R9 hold
        wr(16'h5A8B, 1'b0);
        chk(rd_data == 16'h6983, "R9 hold readback", rd_data, 16'h6983);
        run(200, 1'b0);
        chk(n_rst == 0, "R9 held no expiry", n_rst, 0);
        run(10, 1'b0);
        wr(16'h5A03, 1'b0);
        run(70, 1'b0);
        chk(f_rst == 64, "R9 resume from frozen zero", f_rst, 64);

        // R8 source select
        wr(16'h5A0F, 1'b0);
        run(200, 1'b0);
        chk(n_rst == 0, "R8 unselected tick ignored", n_rst, 0);
        run(70, 1'b1);
        chk(f_rst == 64, "R8 selected tick counts", f_rst, 64);

        // R2 bad key
        wr(16'hA5F0, 1'b0);
        chk(rst_req == 1'b1, "R2 bad key reset pulse", rst_req, 1);
        chk(rd_data == 16'h6907, "R2 config unchanged", rd_data, 16'h6907);
        @(posedge clk); #1;
        chk(rst_req == 1'b0, "R2 pulse one cycle", rst_req, 0);

        // R10 clear in the terminal-tick cycle
        wr(16'h5A0B, 1'b0);
        run(63, 1'b0);
        chk(n_rst == 0, "R10 not yet expired", n_rst, 0);
        wr(16'h5A0B, 1'b1);
        chk(rst_req == 1'b0, "R10 clear beats terminal tick", rst_req, 0);
        run(66, 1'b0);
        chk(f_rst == 64, "R10 full interval after clear", f_rst, 64);

        // R11 bad key in the terminal-tick cycle
        wr(16'h5A0B, 1'b0);
        run(63, 1'b0);
        wr(16'h1203, 1'b1);
        chk(rst_req == 1'b1, "R11 reset pulse", rst_req, 1);
        @(posedge clk); #1;
        chk(rst_req == 1'b0, "R11 single pulse", rst_req, 0);
        run(66, 1'b0);
        chk(f_rst == 64, "R11 counter wrapped", f_rst, 64);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule